// File: doc/BRIEF.md
# Auto-Reload PWM Timer

This block is an 8-bit up-counting timer with a small byte-wide register interface. A clock-source switch picks either the system clock or a synchronised external clock as the input tick. A 7-bit prescaler divides the tick by a power of two from 1 to 128, and the divided tick advances the counter. When the counter leaves FFh it is loaded from a programmable reload register rather than wrapping to zero. That event sets an overflow flag, which can raise an interrupt request, and drives the single PWM output to a programmed level. The reload value therefore sets both the period and the resolution of the output.

Software reaches four byte registers through an address, a write strobe and a read strobe. The control/status register holds the clock source, the division code, the run bit, a write-only force-reload bit, the interrupt enable and the overflow flag. Reading the control/status register clears the flag. The counter access register reads the live count and can overwrite it while the timer runs. A separate level register holds the PWM polarity.

A two-state machine governs the run bit. In TMR_HALT the prescaler and the counter are frozen. In TMR_COUNT both advance. The transition *start* (TMR_HALT to TMR_COUNT) is taken on a control write with the run bit set. The transition *stop* (TMR_COUNT to TMR_HALT) is taken on a control write with the run bit clear. Any other cycle keeps the current state.

Top module: `arpwm_timer`

## Requirements
- R1: After reset, all four registers read 00h, and `irq` and `pwm_out` are low.
- R2: The address map is 0 = control/status, 1 = counter access, 2 = reload, 3 = level. Level bit 0 is the PWM polarity and its other bits read 0. Read data is combinational and valid in the cycle `bus_rd` is high. The control/status layout is: bit 7 = external source, bits 6:4 = division code, bit 3 = run, bit 2 = force reload, bit 1 = interrupt enable, bit 0 = overflow flag.
- R3: Division code c divides the input tick by 2^c. Starting from a cleared prescaler, N enabled input ticks advance the counter floor(N / 2^c) times.
- R4: While the run bit is 0, neither the prescaler nor the counter changes, and the run bit reads 0.
- R5: An advance from FFh loads the reload value and counts as an overflow. Any other advance adds one.
- R6: An overflow sets the flag, and a control/status read clears it. If an overflow and that read fall in the same cycle, the flag stays set.
- R7: `irq` is high exactly when both the flag and the interrupt enable are set.
- R8: Each overflow drives `pwm_out` to the level bit in force at that cycle. Without an overflow, `pwm_out` holds its value.
- R9: Writing 1 to the force-reload bit loads the reload value into the counter and clears the prescaler. The bit always reads 0.
- R10: A counter-access read returns the live count. A counter-access write sets the count and takes priority over an advance in the same cycle, and it leaves the prescaler phase untouched.
- R11: With the external source selected and division code 0, each rising edge of `ext_clk` (high and low for at least two clocks each) advances the counter once, three clock cycles after the edge.
- R12: The state machine moves TMR_HALT to TMR_COUNT only on a control write with bit 3 set, and TMR_COUNT to TMR_HALT only on a control write with bit 3 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | Asynchronous external count source |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, clears the flag on a control/status read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Overflow interrupt request |
| pwm_out | output | 1 | PWM output, set to the level bit on overflow |

## Verification
A wrong prescaler phase or division mask changes the count after a fixed number of enabled cycles. The error shows up at the next counter-access read, and the bench sweeps every division code across hundreds of ticks, so an error of a single tick is caught. A wrong reload path or a wrong overflow detect shifts the final count and the flag on that same read, and the bench exercises reload values up to FFh. Flag races, the gating of the interrupt and the level on the PWM output are sampled in the cycle after the overflow edge, so a fault in any of them appears within one cycle.

// File: rtl/arpwm_pkg.sv
package arpwm_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT    = 2'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 2'd2;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 2'd3;

    localparam int unsigned B_SRC   = 7;
    localparam int unsigned B_SELHI = 6;
    localparam int unsigned B_SELLO = 4;
    localparam int unsigned B_RUN   = 3;
    localparam int unsigned B_FORCE = 2;
    localparam int unsigned B_IEN   = 1;
    localparam int unsigned B_FLAG  = 0;

    typedef enum logic {
        TMR_HALT  = 1'b0,
        TMR_COUNT = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/arpwm_clksel.sv
module arpwm_clksel #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic use_ext,
    output logic in_tick
);
    localparam int unsigned SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;
    logic            rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SH_W-2:0], ext_clk};
        end
    end

    always_comb begin
        rise    = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
        in_tick = use_ext ? rise : 1'b1;
    end

    // R11
    ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/arpwm_prescaler.sv
module arpwm_prescaler #(
    parameter int unsigned PRE_W = 7,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             in_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(sel));
        end
        tick = run & in_tick & ((pre_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (run && in_tick) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R4
    prsc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(pre_q));

    // R9
    prsc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));

endmodule

// File: rtl/arpwm_counter.sv
module arpwm_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         ld_en,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic at_top;

    always_comb begin
        at_top = (cnt == {W{1'b1}});
        ovf    = step & ~wr_en & ~ld_en & at_top;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wr_val;
        end else if (ld_en) begin
            cnt <= reload;
        end else if (step) begin
            cnt <= at_top ? reload : cnt + 1'b1;
        end
    end

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == $past(reload)));

    // R10
    acc_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt == $past(wr_val)));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_en && !ld_en) |=> $stable(cnt));

endmodule

// File: rtl/arpwm_timer.sv
module arpwm_timer
    import arpwm_pkg::*;
#(
    parameter int unsigned PRE_W       = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              pwm_out
);
    localparam int unsigned SEL_W = $clog2(PRE_W + 1);

    tmr_state_e        state_q, state_d;
    logic              run;
    logic              src_ext;
    logic [SEL_W-1:0]  div_sel;
    logic              ien;
    logic              flag;
    logic              level;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] cnt;
    logic              ovf;
    logic              in_tick;
    logic              step;
    logic              wr_ctrl, wr_cnt, wr_reload, wr_level, rd_ctrl, force_ld;

    always_comb begin
        wr_ctrl   = bus_wr & (bus_addr == A_CTRL);
        wr_cnt    = bus_wr & (bus_addr == A_CNT);
        wr_reload = bus_wr & (bus_addr == A_RELOAD);
        wr_level  = bus_wr & (bus_addr == A_LEVEL);
        rd_ctrl   = bus_rd & (bus_addr == A_CTRL);
        force_ld  = wr_ctrl & bus_wdata[B_FORCE];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_HALT:  if (wr_ctrl && bus_wdata[B_RUN])  state_d = TMR_COUNT;
            TMR_COUNT: if (wr_ctrl && !bus_wdata[B_RUN]) state_d = TMR_HALT;
            default:   state_d = TMR_HALT;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        unique case (state_q)
            TMR_COUNT: run = 1'b1;
            default:   run = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_ext  <= 1'b0;
            div_sel  <= '0;
            ien      <= 1'b0;
            reload_q <= '0;
            level    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                src_ext <= bus_wdata[B_SRC];
                div_sel <= bus_wdata[B_SELHI:B_SELLO];
                ien     <= bus_wdata[B_IEN];
            end
            if (wr_reload) reload_q <= bus_wdata;
            if (wr_level)  level    <= bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag    <= 1'b0;
            pwm_out <= 1'b0;
        end else begin
            if (ovf)          flag <= 1'b1;
            else if (rd_ctrl) flag <= 1'b0;
            if (ovf)          pwm_out <= level;
        end
    end

    always_comb begin
        irq = flag & ien;
        unique case (bus_addr)
            A_CTRL:   bus_rdata = {src_ext, div_sel, run, 1'b0, ien, flag};
            A_CNT:    bus_rdata = cnt;
            A_RELOAD: bus_rdata = reload_q;
            default:  bus_rdata = {{(DATA_W-1){1'b0}}, level};
        endcase
    end

    arpwm_clksel #(.SYNC_STAGES(SYNC_STAGES)) u_clksel (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_clk (ext_clk),
        .use_ext (src_ext),
        .in_tick (in_tick)
    );

    arpwm_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clr     (force_ld),
        .in_tick (in_tick),
        .sel     (div_sel),
        .tick    (step)
    );

    arpwm_counter #(.W(DATA_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .wr_en  (wr_cnt),
        .wr_val (bus_wdata),
        .ld_en  (force_ld),
        .reload (reload_q),
        .cnt    (cnt),
        .ovf    (ovf)
    );

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);

    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !ovf) |=> !flag);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_ctrl && !wr_ctrl) |=> irq);

    // R8
    pwm_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (pwm_out == $past(level)));

    // R8
    pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |=> $stable(pwm_out));

    // R12
    fsm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(state_q));

endmodule

// File: tb/arpwm_timer_tb.sv
module arpwm_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       pwm_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arpwm_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk   (ext_clk),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] csr(input bit src, input int sel, input bit en,
                                       input bit frc, input bit ie);
        return {src, 3'(sel), en, frc, ie, 1'b0};
    endfunction

    // R3 R5: arithmetic model of k counter advances
    function automatic logic [7:0] model(input int s, input int r, input int k, output int novf);
        int v = s;
        novf = 0;
        for (int i = 0; i < k; i++) begin
            if (v == 255) begin v = r; novf++; end
            else v++;
        end
        return 8'(v);
    endfunction

    task automatic run_case(input int sel, input int s, input int r, input int m);
        logic [7:0] d;
        logic [7:0] exp;
        int novf;
        wr(2'd2, 8'(r));
        wr(2'd0, csr(0, sel, 0, 1, 0));        // force reload, prescaler cleared
        rd(2'd1, d); check("R9 force reload value", d, 8'(r));
        wr(2'd1, 8'(s));
        rd(2'd0, d);                            // clear flag
        wr(2'd0, csr(0, sel, 1, 0, 0));
        idle(m);
        check("R7 irq low with enable 0", {7'b0, irq}, 8'h00);
        wr(2'd0, csr(0, sel, 0, 0, 0));
        exp = model(s, r, (m + 1) >> sel, novf);
        rd(2'd1, d); check("R3 R5 count after sweep", d, exp);
        rd(2'd0, d); check("R6 flag after sweep", {7'b0, d[0]}, {7'b0, novf > 0});
        rd(2'd0, d); check("R6 flag cleared by read", {7'b0, d[0]}, 8'h00);
    endtask

    initial begin
        logic [7:0] d;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); check("R1 reset register", d, 8'h00);
        end
        check("R1 reset irq", {7'b0, irq}, 8'h00);
        check("R1 reset pwm", {7'b0, pwm_out}, 8'h00);

        // R2 control readback and level layout; R9 force bit reads 0
        wr(2'd0, csr(1, 5, 0, 1, 1));
        rd(2'd0, d); check("R2 R9 control readback", d, 8'hD2);
        wr(2'd3, 8'hFF);
        rd(2'd3, d); check("R2 level readback", d, 8'h01);
        wr(2'd3, 8'h00);
        wr(2'd0, 8'h00);

        // R3 R5 sweep over every division code
        for (int c = 0; c < 8; c++) begin
            run_case(c, 8'hF0 - c * 3, c * 20, 300 + c * 37);
        end
        // R5 reload boundary values
        run_case(0, 8'h00, 8'h00, 600);
        run_case(0, 8'h80, 8'h80, 500);
        run_case(0, 8'hE0, 8'hE0, 77);
        run_case(0, 8'hFE, 8'hFE, 9);
        run_case(0, 8'hFF, 8'hFF, 5);
        run_case(1, 8'h10, 8'hF0, 150);

        // R4 freeze
        wr(2'd1, 8'h33);
        idle(50);
        rd(2'd1, d); check("R4 counter frozen", d, 8'h33);
        rd(2'd0, d); check("R4 R12 run bit stays 0", {7'b0, d[3]}, 8'h00);

        // R10 live read and write priority
        wr(2'd1, 8'h05);
        wr(2'd0, csr(0, 0, 1, 0, 0));
        rd(2'd1, d); check("R10 live read 1", d, 8'h05);
        rd(2'd1, d); check("R10 live read 2", d, 8'h06);
        rd(2'd0, d); check("R12 run bit reads 1", {7'b0, d[3]}, 8'h01);
        wr(2'd1, 8'h40);
        wr(2'd0, csr(0, 0, 0, 0, 0));
        rd(2'd1, d); check("R10 write wins over advance", d, 8'h41);

        // R6 same-cycle overflow and read, R7 irq
        wr(2'd2, 8'h10);
        wr(2'd1, 8'hFF);
        rd(2'd0, d);
        wr(2'd0, csr(0, 0, 1, 0, 1));
        rd(2'd0, d); check("R6 flag before race", {7'b0, d[0]}, 8'h00);
        wr(2'd0, csr(0, 0, 0, 0, 1));
        check("R7 irq high", {7'b0, irq}, 8'h01);
        rd(2'd0, d); check("R6 flag kept on race", {7'b0, d[0]}, 8'h01);
        check("R7 irq low after read", {7'b0, irq}, 8'h00);

        // R8 pwm level on overflow
        wr(2'd3, 8'h01);
        wr(2'd1, 8'hFE);
        wr(2'd0, csr(0, 0, 1, 0, 0));
        idle(1);
        check("R8 pwm before overflow", {7'b0, pwm_out}, 8'h00);
        idle(3);
        check("R8 pwm after overflow", {7'b0, pwm_out}, 8'h01);
        wr(2'd0, csr(0, 0, 0, 0, 0));
        wr(2'd3, 8'h00);
        idle(5);
        check("R8 pwm holds", {7'b0, pwm_out}, 8'h01);
        wr(2'd1, 8'hFF);
        wr(2'd0, csr(0, 0, 1, 0, 0));
        idle(3);
        wr(2'd0, csr(0, 0, 0, 0, 0));
        check("R8 pwm driven low", {7'b0, pwm_out}, 8'h00);

        // R9 force reload while running, cleared prescaler
        wr(2'd2, 8'h37);
        wr(2'd0, csr(0, 3, 1, 0, 0));
        idle(13);
        wr(2'd0, csr(0, 3, 1, 1, 0));
        idle(40);
        wr(2'd0, csr(0, 3, 0, 0, 0));
        rd(2'd1, d); check("R9 reload and prescaler clear", d, 8'h37 + 8'(41 >> 3));

        // R11 external clock
        wr(2'd1, 8'h10);
        wr(2'd0, csr(1, 0, 1, 0, 0));
        idle(4);
        for (int p = 0; p < 9; p++) begin
            ext_clk = 1'b1; idle(3);
            ext_clk = 1'b0; idle(3);
        end
        idle(4);
        wr(2'd0, csr(1, 0, 0, 0, 0));
        rd(2'd1, d); check("R11 external edges counted", d, 8'h19);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule